// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches three axes of signed acceleration samples and recognises short, sharp pulses ("taps"). A pulse is the magnitude of an axis rising above that axis's threshold and dropping back below it before a time limit runs out. One valid pulse is a single tap. A double tap is a second valid pulse that starts after a blanking latency and before a second-start window closes. Samples arrive with a valid strobe. Two tick enables pace the timers: a fast tick for the pulse time limit, and a slow tick at half that rate for latency and window.

A small register port sets the thresholds, the three timer limits and a configuration byte. The configuration byte selects, per axis and per event type, which events are reported. It also selects latched or auto-clearing status and whether an early pulse aborts a pending double tap. The block presents an 8-bit source word and an event flag for an interrupt controller. Software clears a latched source word by reading it.

Top module: `tapdet_top`

## Requirements
- R1: Each axis has a 7-bit unsigned threshold at register addresses 2 (X), 3 (Y) and 4 (Z). An axis is "above" only when the absolute value of its two's-complement sample is strictly greater than the threshold. Bit 7 of a threshold register reads as 0.
- R2: A pulse is valid when a sample with no enabled axis above arrives before the pulse time-limit counter expires. The counter expires on fast tick number max(L,1) after the pulse starts, where L is the time limit at address 5. If it expires while the pulse is still high, no event is raised and detection restarts only after a sample below threshold.
- R3: After every valid pulse, a latency period of max(N,1) slow ticks runs, where N is the latency at address 6. A pulse that starts during latency never starts second-pulse detection.
- R4: After latency, a window of max(W,1) slow ticks runs, where W is at address 7. A second pulse must start before the window expires but may end after it. If the window expires with no second pulse, the detector returns to idle, so the next pulse counts as a first pulse.
- R5: If an enabled axis is above its threshold at the moment latency ends, second-pulse detection starts at once.
- R6: The configuration byte at address 0 holds: bit 7 abort, bit 6 latch, bit 5 Z double, bit 4 Z single, bit 3 Y double, bit 2 Y single, bit 1 X double, bit 0 X single. An axis takes part in detection if either of its enables is set.
- R7: With abort set, a pulse starting during latency cancels the pending double tap. With abort clear, that pulse is ignored and a later pulse in the window still forms a double tap.
- R8: The source word holds: bit 7 event active, bit 6 Z event, bit 5 Y event, bit 4 X event, bit 3 double flag, bit 2 Z negative, bit 1 Y negative, bit 0 X negative. An axis bit is set only when that axis was above during the pulse and its enable for that event type is set. A polarity bit is 1 when the axis's sample was negative at its crossing. When event active is 0 the whole word is 0.
- R9: With latch clear, the source word clears when the latency that follows the event ends. With latch set, the source word is frozen, and later events are not recorded, until it is read at address 1, which clears it.
- R10: Only the fast tick advances the time limit. Only the slow tick advances latency and window.
- R11: Threshold registers may be rewritten while a pulse is in progress. The new value applies from the next sample and does not reset detection.
- R12: The event flag output equals bit 7 of the source word, and reading address 1 returns the source word.
- R13: After reset, all registers and the source word are zero and the event flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe for all three axes |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| tick_fast | input | 1 | Time-limit tick enable |
| tick_slow | input | 1 | Latency and window tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears latched source word at address 1) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| src_word | output | 8 | Source status word |
| evt_irq | output | 1 | Event flag to the interrupt controller |

## Verification
Two situations are hardest to reach. The first is a pulse that begins inside latency and is still above threshold when latency ends. The second is a second pulse that starts just before the window closes and ends after it. Both depend on the exact order of samples relative to slow ticks. The bench drives ticks and samples as separate one-cycle strobes, so it can place a sample between a chosen pair of slow ticks. It then shows whether a double tap appears, and with which flags, in the source word.

// File: rtl/tapdet_pkg.sv
package tapdet_pkg;
   localparam int NAX = 3;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_P1    = 3'd1,
      ST_LAT   = 3'd2,
      ST_WIN   = 3'd3,
      ST_P2    = 3'd4,
      ST_DRAIN = 3'd5
   } tap_st_e;

   localparam int ADR_CFG  = 0;
   localparam int ADR_SRC  = 1;
   localparam int ADR_THX  = 2;
   localparam int ADR_TLIM = 5;
   localparam int ADR_LTCY = 6;
   localparam int ADR_WIND = 7;

   localparam int CFG_ABORT = 7;
   localparam int CFG_LATCH = 6;

   function automatic logic [NAX-1:0] en_single(input logic [7:0] c);
      return {c[4], c[2], c[0]};
   endfunction

   function automatic logic [NAX-1:0] en_double(input logic [7:0] c);
      return {c[5], c[3], c[1]};
   endfunction
endpackage

// File: rtl/tapdet_axis.sv
module tapdet_axis #(
   parameter int DW = 8,
   parameter int TW = 7
) (
   input  logic [DW-1:0] smp,
   input  logic [TW-1:0] thr,
   output logic          above,
   output logic          neg
);
   localparam int MW = DW + 1;

   logic [MW-1:0] ext;
   logic [MW-1:0] mag;

   always_comb begin
      ext = {smp[DW-1], smp};
      mag = smp[DW-1] ? (~ext + 1'b1) : ext;
   end

   assign above = (mag > MW'(thr));
   assign neg   = smp[DW-1];
endmodule

// File: rtl/tapdet_timer.sv
module tapdet_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          expire
);
   logic [CW-1:0] cnt;
   logic [CW:0]   nxt;

   assign nxt    = (CW+1)'(cnt) + 1'b1;
   assign expire = run & tick & (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run)             cnt <= '0;
      else if (tick && !expire)  cnt <= nxt[CW-1:0];
   end
endmodule

// File: rtl/tapdet_regs.sv
module tapdet_regs
   import tapdet_pkg::*;
#(
   parameter int AW = 3,
   parameter int RW = 8,
   parameter int TW = 7,
   parameter int CW = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic                    rd,
   input  logic [AW-1:0]           addr,
   input  logic [RW-1:0]           wdata,
   input  logic                    evt_stb,
   input  logic                    evt_dbl,
   input  logic [NAX-1:0]          evt_axes,
   input  logic [NAX-1:0]          evt_pol,
   input  logic                    lat_done,
   output logic [7:0]              cfg,
   output logic [NAX-1:0][TW-1:0]  thr,
   output logic [CW-1:0]           tlim,
   output logic [CW-1:0]           ltcy,
   output logic [CW-1:0]           wind,
   output logic [7:0]              src,
   output logic [RW-1:0]           rdata
);
   logic       rd_src;
   logic [7:0] src_n;

   assign rd_src = rd && (addr == AW'(ADR_SRC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         tlim <= '0;
         ltcy <= '0;
         wind <= '0;
      end else if (wr) begin
         if (addr == AW'(ADR_CFG))  cfg  <= wdata[7:0];
         if (addr == AW'(ADR_TLIM)) tlim <= wdata[CW-1:0];
         if (addr == AW'(ADR_LTCY)) ltcy <= wdata[CW-1:0];
         if (addr == AW'(ADR_WIND)) wind <= wdata[CW-1:0];
      end
   end

   for (genvar g = 0; g < NAX; g++) begin : g_thr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            thr[g] <= '0;
         else if (wr && (addr == AW'(ADR_THX + g)))
            thr[g] <= wdata[TW-1:0];
      end
   end

   always_comb begin
      src_n = src;
      if (cfg[CFG_LATCH]) begin
         if (rd_src) src_n = '0;
      end else if (lat_done) begin
         src_n = '0;
      end
      if (evt_stb && !(cfg[CFG_LATCH] && src_n[7]))
         src_n = {1'b1, evt_axes, evt_dbl, evt_pol};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src <= '0;
      else        src <= src_n;
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADR_CFG))  rdata = RW'(cfg);
      if (addr == AW'(ADR_SRC))  rdata = RW'(src);
      if (addr == AW'(ADR_TLIM)) rdata = RW'(tlim);
      if (addr == AW'(ADR_LTCY)) rdata = RW'(ltcy);
      if (addr == AW'(ADR_WIND)) rdata = RW'(wind);
      for (int i = 0; i < NAX; i++)
         if (addr == AW'(ADR_THX + i)) rdata = RW'(thr[i]);
   end
endmodule

// File: rtl/tapdet_fsm.sv
module tapdet_fsm
   import tapdet_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   input  logic [NAX-1:0] above,
   input  logic [NAX-1:0] neg,
   input  logic [7:0]     cfg,
   input  logic           t_exp,
   input  logic           l_exp,
   input  logic           w_exp,
   output logic           t_run,
   output logic           l_run,
   output logic           w_run,
   output logic           evt_stb,
   output logic           evt_dbl,
   output logic [NAX-1:0] evt_axes,
   output logic [NAX-1:0] evt_pol,
   output logic           lat_done,
   output logic [2:0]     st_o
);
   tap_st_e        st, st_n;
   logic [NAX-1:0] cap, cap_n, pol, pol_n;
   logic [NAX-1:0] prev_hit, prev_neg;
   logic           second, second_n;

   logic [NAX-1:0] es, ed, hit, lvl_hit, lvl_neg;
   logic           any, rise;

   assign es      = en_single(cfg);
   assign ed      = en_double(cfg);
   assign hit     = above & (es | ed);
   assign any     = |hit;
   assign lvl_hit = smp_valid ? hit : prev_hit;
   assign lvl_neg = smp_valid ? neg : prev_neg;
   assign rise    = smp_valid & any & ~(|prev_hit);

   assign t_run = (st == ST_P1) || (st == ST_P2);
   assign l_run = (st == ST_LAT);
   assign w_run = (st == ST_WIN);
   assign st_o  = st;

   always_comb begin
      st_n     = st;
      cap_n    = cap;
      pol_n    = pol;
      second_n = second;
      evt_stb  = 1'b0;
      evt_dbl  = 1'b0;
      evt_axes = '0;
      evt_pol  = '0;
      lat_done = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (smp_valid && any) begin
               st_n  = ST_P1;
               cap_n = hit;
               pol_n = neg & hit;
            end
         end
         ST_P1, ST_P2: begin
            if (smp_valid && !any) begin
               if (st == ST_P1) begin
                  evt_axes = cap & es;
                  second_n = 1'b0;
               end else begin
                  evt_axes = cap & ed;
                  evt_dbl  = 1'b1;
                  second_n = 1'b1;
               end
               evt_stb = |evt_axes;
               evt_pol = pol & evt_axes;
               st_n    = ST_LAT;
            end else if (t_exp) begin
               st_n = ST_DRAIN;
            end else if (smp_valid) begin
               cap_n = cap | hit;
               pol_n = pol | (neg & hit & ~cap);
            end
         end
         ST_LAT: begin
            if (rise && cfg[CFG_ABORT]) begin
               lat_done = 1'b1;
               st_n     = ST_DRAIN;
            end else if (l_exp) begin
               lat_done = 1'b1;
               if (second || !(|(cap & ed))) begin
                  st_n = ST_IDLE;
               end else if (|lvl_hit) begin
                  st_n  = ST_P2;
                  cap_n = lvl_hit;
                  pol_n = lvl_neg & lvl_hit;
               end else begin
                  st_n = ST_WIN;
               end
            end
         end
         ST_WIN: begin
            if (smp_valid && any) begin
               st_n  = ST_P2;
               cap_n = hit;
               pol_n = neg & hit;
            end else if (w_exp) begin
               st_n = ST_IDLE;
            end
         end
         ST_DRAIN: begin
            if (smp_valid && !any) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cap      <= '0;
         pol      <= '0;
         second   <= 1'b0;
         prev_hit <= '0;
         prev_neg <= '0;
      end else begin
         st     <= st_n;
         cap    <= cap_n;
         pol    <= pol_n;
         second <= second_n;
         if (smp_valid) begin
            prev_hit <= hit;
            prev_neg <= neg;
         end
      end
   end
endmodule

// File: rtl/tapdet_top.sv
module tapdet_top
   import tapdet_pkg::*;
#(
   parameter int DW = 8,
   parameter int TW = 7,
   parameter int CW = 8,
   parameter int AW = 3,
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_x,
   input  logic [DW-1:0] smp_y,
   input  logic [DW-1:0] smp_z,
   input  logic          tick_fast,
   input  logic          tick_slow,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic [7:0]    src_word,
   output logic          evt_irq
);
   if (TW >= DW) begin : g_bad_tw
      $error("threshold width must be below sample width");
   end
   if (RW < 8) begin : g_bad_rw
      $error("register width must hold the configuration byte");
   end
   if (CW > RW || TW > RW) begin : g_bad_cw
      $error("timer and threshold fields must fit a register");
   end
   if (AW < 3) begin : g_bad_aw
      $error("address must reach eight registers");
   end

   logic [NAX-1:0][DW-1:0] smp;
   logic [NAX-1:0][TW-1:0] thr;
   logic [NAX-1:0]         above, neg;
   logic [7:0]             cfg_q, src_q;
   logic [CW-1:0]          tlim, ltcy, wind;
   logic                   t_run, l_run, w_run, t_exp, l_exp, w_exp;
   logic                   evt_stb, evt_dbl, lat_done;
   logic [NAX-1:0]         evt_axes, evt_pol;
   logic [2:0]             fsm_st;

   assign smp = {smp_z, smp_y, smp_x};

   tapdet_regs #(.AW(AW), .RW(RW), .TW(TW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .evt_stb(evt_stb), .evt_dbl(evt_dbl),
      .evt_axes(evt_axes), .evt_pol(evt_pol), .lat_done(lat_done),
      .cfg(cfg_q), .thr(thr), .tlim(tlim), .ltcy(ltcy), .wind(wind),
      .src(src_q), .rdata(reg_rdata)
   );

   for (genvar g = 0; g < NAX; g++) begin : g_axis
      tapdet_axis #(.DW(DW), .TW(TW)) u_axis (
         .smp(smp[g]), .thr(thr[g]), .above(above[g]), .neg(neg[g])
      );
   end

   tapdet_timer #(.CW(CW)) u_tlim (
      .clk(clk), .rst_n(rst_n), .run(t_run), .tick(tick_fast),
      .limit(tlim), .expire(t_exp)
   );
   tapdet_timer #(.CW(CW)) u_ltcy (
      .clk(clk), .rst_n(rst_n), .run(l_run), .tick(tick_slow),
      .limit(ltcy), .expire(l_exp)
   );
   tapdet_timer #(.CW(CW)) u_wind (
      .clk(clk), .rst_n(rst_n), .run(w_run), .tick(tick_slow),
      .limit(wind), .expire(w_exp)
   );

   tapdet_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .above(above),
      .neg(neg), .cfg(cfg_q), .t_exp(t_exp), .l_exp(l_exp), .w_exp(w_exp),
      .t_run(t_run), .l_run(l_run), .w_run(w_run), .evt_stb(evt_stb),
      .evt_dbl(evt_dbl), .evt_axes(evt_axes), .evt_pol(evt_pol),
      .lat_done(lat_done), .st_o(fsm_st)
   );

   assign src_word = src_q;
   assign evt_irq  = src_q[7];
endmodule

// File: rtl/tapdet_chk.sv
module tapdet_chk
   import tapdet_pkg::*;
#(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    cfg,
   input logic [7:0]    src,
   input logic          reg_rd,
   input logic [AW-1:0] reg_addr,
   input logic          t_run,
   input logic          l_run,
   input logic          w_run,
   input logic [2:0]    st,
   input logic          evt_stb,
   input logic          lat_done
);
   AST_SRC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !src[7] |-> (src == 8'h00)); // R8

   AST_LATCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[CFG_LATCH] && src[7] && !(reg_rd && reg_addr == AW'(ADR_SRC)))
      |=> (src == $past(src))); // R9

   AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[CFG_LATCH] && lat_done) |=> (src == 8'h00)); // R9

   AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src[7]) |-> ((src[6:4] & ~(src[3] ? $past(en_double(cfg))
                                              : $past(en_single(cfg)))) == 3'b000)); // R8

   AST_ONE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({t_run, l_run, w_run})); // R3

   AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'(ST_DRAIN)) |-> !evt_stb); // R2
endmodule

bind tapdet_top tapdet_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .src(src_q), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .t_run(t_run), .l_run(l_run), .w_run(w_run),
   .st(fsm_st), .evt_stb(evt_stb), .lat_done(lat_done)
);

// File: tb/tapdet_top_test.sv
module tapdet_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic [7:0] sx = '0, sy = '0, sz = '0;
   logic       tf = 1'b0, ts = 1'b0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, src_word;
   logic       evt_irq;

   int errs = 0;
   int nchk = 0;

   localparam logic [7:0] HI  = 8'd50;
   localparam logic [7:0] LOW = 8'hCE;   // -50
   localparam logic [7:0] Q   = 8'd0;

   always #5 clk = ~clk;

   tapdet_top uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(sx), .smp_y(sy),
      .smp_z(sz), .tick_fast(tf), .tick_slow(ts), .reg_wr(wr), .reg_rd(rd),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .src_word(src_word), .evt_irq(evt_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic smp(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
      @(negedge clk); smp_valid = 1'b1; sx = x; sy = y; sz = z;
      @(negedge clk); smp_valid = 1'b0;
   endtask

   task automatic fast(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tf = 1'b1;
         @(negedge clk); tf = 1'b0;
      end
   endtask

   task automatic slow(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ts = 1'b1;
         @(negedge clk); ts = 1'b0;
      end
   endtask

   task automatic setup(input logic [7:0] c);
      wreg(3'd2, 8'd32); wreg(3'd3, 8'd32); wreg(3'd4, 8'd32);
      wreg(3'd5, 8'd4);  wreg(3'd6, 8'd3);  wreg(3'd7, 8'd4);
      wreg(3'd0, c);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R13 src after reset", src_word, 8'h00);
      chk("R13 irq after reset", {7'd0, evt_irq}, 8'h00);
      rreg(3'd0, d); chk("R13 cfg reset", d, 8'h00);
      rreg(3'd5, d); chk("R13 tlim reset", d, 8'h00);
   endtask

   task automatic t_single;
      setup(8'h15);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R8 single X src", src_word, 8'h90);
      chk("R12 irq follows", {7'd0, evt_irq}, 8'h01);
      fast(10);
      chk("R10 fast tick leaves latency", src_word, 8'h90);
      slow(2);
      chk("R9 held during latency", src_word, 8'h90);
      slow(1);
      chk("R9 auto clear at latency end", src_word, 8'h00);
   endtask

   task automatic t_invalid;
      setup(8'h15);
      smp(Q, Q, LOW); fast(4); smp(Q, Q, Q);
      chk("R2 expired pulse silent", src_word, 8'h00);
      smp(Q, Q, LOW); fast(3); smp(Q, Q, Q);
      chk("R2 R8 valid Z negative", src_word, 8'hC4);
      slow(3);
   endtask

   task automatic t_ticks;
      setup(8'h15);
      smp(HI, Q, Q); slow(6); smp(Q, Q, Q);
      chk("R10 slow tick leaves limit", src_word, 8'h90);
      slow(3);
   endtask

   task automatic t_thresh;
      logic [7:0] d;
      setup(8'h15);
      smp(8'd32, Q, Q); smp(Q, Q, Q);
      chk("R1 equal is not above", src_word, 8'h00);
      smp(HI, Q, Q);
      wreg(3'd2, 8'd60);
      smp(HI, Q, Q);
      chk("R11 new threshold ends pulse", src_word, 8'h90);
      slow(3);
      wreg(3'd2, 8'hFF);
      rreg(3'd2, d); chk("R1 threshold msb reads zero", d, 8'h7F);
      wreg(3'd2, 8'd32);
   endtask

   task automatic t_double_latched;
      logic [7:0] d;
      setup(8'h6A);
      smp(Q, HI, Q); smp(Q, Q, Q);
      chk("R8 single disabled no event", src_word, 8'h00);
      slow(3); smp(Q, LOW, Q); smp(Q, Q, Q);
      chk("R6 R8 double Y negative", src_word, 8'hAA);
      slow(3);
      chk("R9 latched past latency", src_word, 8'hAA);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(3); smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R9 latched ignores new event", src_word, 8'hAA);
      slow(3);
      rreg(3'd1, d); chk("R12 read source", d, 8'hAA);
      chk("R9 read clears latch", src_word, 8'h00);
   endtask

   task automatic t_abort;
      setup(8'hAA);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(1);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R7 abort no double", src_word, 8'h00);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R7 restart as first pulse", src_word, 8'h00);
      slow(3); smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R7 double after abort", src_word, 8'h98);
      slow(3);
   endtask

   task automatic t_noabort;
      setup(8'h2A);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(1);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R3 pulse in latency ignored", src_word, 8'h00);
      slow(2); smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R7 double without abort", src_word, 8'h98);
      slow(3);
   endtask

   task automatic t_level;
      setup(8'h2A);
      smp(Q, Q, HI); smp(Q, Q, Q); slow(1);
      smp(Q, Q, HI); slow(2);
      chk("R5 no event yet", src_word, 8'h00);
      smp(Q, Q, Q);
      chk("R5 above at latency end", src_word, 8'hC8);
      slow(3);
   endtask

   task automatic t_window;
      setup(8'h2A);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(3); slow(4);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R4 window expiry to idle", src_word, 8'h00);
      slow(7);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(3); slow(3);
      smp(HI, Q, Q); slow(2); smp(Q, Q, Q);
      chk("R4 second ends after window", src_word, 8'h98);
      slow(3);
   endtask

   task automatic t_long_second;
      setup(8'h2A);
      smp(HI, Q, Q); smp(Q, Q, Q); slow(3);
      smp(HI, Q, Q); fast(4); smp(Q, Q, Q);
      chk("R2 long second rejected", src_word, 8'h00);
   endtask

   task automatic t_both;
      setup(8'h3F);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R6 both single seen", src_word, 8'h90);
      slow(3);
      chk("R9 cleared before window", src_word, 8'h00);
      smp(HI, Q, Q); smp(Q, Q, Q);
      chk("R6 both double seen", src_word, 8'h98);
      slow(3);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_invalid();
      t_ticks();
      t_thresh();
      t_double_latched();
      t_abort();
      t_noabort();
      t_level();
      t_window();
      t_long_second();
      t_both();
      summary();
   end
endmodule